// File: doc/BRIEF.md
# Substitution Table Lookup Unit

This unit performs byte-indexed table substitution for a 32-bit cipher datapath in a single cycle. It holds four tables. Each table has 256 words of 32 bits, all in local storage inside the block. A lookup supplies a 32-bit source word, a 2-bit byte selector and a 2-bit table number. The unit picks one byte of the source and forms the table word address by plain concatenation of the table number and that byte, so no adder or shifter sits in the address path. On the next clock edge it returns the stored 32-bit word together with a result-valid strobe.

Every table starts on a 1 KiB boundary, so the byte address of an entry is always {table, index, 2'b00}. The store port therefore takes a word address, {table, index}. Ordinary stores into the tables do not take effect at once. They wait in a four-slot pending buffer and become visible only when a sync command is issued or while the alias flag is high. At that point every pending store is committed to the table storage in the order it arrived. A lookup issued in the same cycle as a commit already sees the committed data.

Top module: `sbox_lookup_unit`

## Requirements
- R1: After synchronous reset, res_valid and st_full are low, and every entry of every table reads as zero.
- R2: res_valid is high in exactly the cycle after a cycle with lk_valid high. In that cycle res_data holds the selected table entry.
- R3: lk_bsel value k selects source bits [8k+7:8k] as the index: 3 selects bits 31:24, 2 selects 23:16, 1 selects 15:8 and 0 selects 7:0.
- R4: A lookup reads word {lk_table, index} of the table storage. The store word address st_addr uses the same layout: bits [9:8] give the table and bits [7:0] give the index.
- R5: A store is invisible to every lookup until a commit has taken place.
- R6: sync_req commits all pending stores. A lookup in the same cycle as sync_req returns the newly committed data.
- R7: A cycle with alias_flag high commits pending stores in the same way as sync_req.
- R8: When several pending stores target the same word, the one accepted last holds the word after the commit.
- R9: A store issued in the same cycle as a commit is not part of that commit. It stays pending until the next commit.
- R10: The pending buffer holds 4 stores, and st_full is high whenever 4 are pending. A store issued while st_full is high and no commit happens in that cycle is discarded and never reaches the tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_src | input | 32 | Source word from which the index byte is taken |
| lk_bsel | input | 2 | Byte selector for the index |
| lk_table | input | 2 | Table number for the lookup |
| st_valid | input | 1 | Store request |
| st_addr | input | 10 | Store word address {table, index} |
| st_data | input | 32 | Store data |
| sync_req | input | 1 | Commit all pending stores |
| alias_flag | input | 1 | While high, commit pending stores each cycle |
| res_valid | output | 1 | Lookup result strobe |
| res_data | output | 32 | Lookup result |
| st_full | output | 1 | Pending buffer holds 4 stores |

## Verification
A lookup result is due one clock edge after its request. A store changes st_full at the next edge, but it changes table contents only at the edge of a later commit. The bench drives its inputs on falling edges. Its reference model advances on each rising edge from the inputs held at that edge. The model's expected res_valid, res_data and st_full are then compared against the design at the following falling edge, so each result is checked in the cycle it is due. Directed sequences exercise the same-cycle commit and lookup, the same-cycle commit and store, repeated stores to one address, and overflow of the buffer. A long run with mixed random traffic follows.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
    localparam int ENTRY_W    = 32;
    localparam int IDX_W      = 8;
    localparam int TBL_CNT    = 4;
    localparam int TSEL_W     = $clog2(TBL_CNT);
    localparam int WADDR_W    = TSEL_W + IDX_W;
    localparam int NWORDS     = TBL_CNT * (1 << IDX_W);
    localparam int BSEL_W     = $clog2(ENTRY_W / IDX_W);
    localparam int WBUF_DEPTH = 4;

    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [ENTRY_W-1:0] data;
    } st_entry_t;

    function automatic logic [IDX_W-1:0] pick_byte(
        input logic [ENTRY_W-1:0] src,
        input logic [BSEL_W-1:0]  sel
    );
        return src[int'(sel)*IDX_W +: IDX_W];
    endfunction
endpackage

// File: rtl/sbox_index_gen.sv
module sbox_index_gen
    import sbox_pkg::*;
(
    input  logic [ENTRY_W-1:0] src,
    input  logic [BSEL_W-1:0]  bsel,
    input  logic [TSEL_W-1:0]  tsel,
    output logic [WADDR_W-1:0] waddr
);
    // Tables sit on 1 KiB boundaries: the word address is a pure concatenation.
    always_comb waddr = {tsel, pick_byte(src, bsel)};
endmodule

// File: rtl/sbox_write_buf.sv
module sbox_write_buf
    import sbox_pkg::*;
#(
    parameter int DEPTH = WBUF_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               st_valid,
    input  logic [WADDR_W-1:0] st_waddr,
    input  logic [ENTRY_W-1:0] st_data,
    input  logic               commit,
    output st_entry_t          pend [DEPTH],
    output logic [DEPTH-1:0]   pend_vld,
    output logic               full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] count;
    st_entry_t        slot [DEPTH];
    st_entry_t        incoming;

    always_comb incoming = '{waddr: st_waddr, data: st_data};
    always_comb full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (commit) begin
            // Entries held before this edge drain; a store in this cycle stays pending.
            count <= st_valid ? CNT_W'(1) : '0;
            if (st_valid) slot[0] <= incoming;
        end else if (st_valid && !full) begin
            slot[count[PTR_W-1:0]] <= incoming;
            count <= count + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        always_comb begin
            pend[g]     = slot[g];
            pend_vld[g] = (CNT_W'(g) < count);
        end
    end

    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    a_r10_drop_when_full: assert property (@(posedge clk) disable iff (rst)
        (full && st_valid && !commit) |=> full);
    a_r6_commit_drains: assert property (@(posedge clk) disable iff (rst)
        commit |=> ($countones(pend_vld) <= 1));
    a_r9_store_on_commit_kept: assert property (@(posedge clk) disable iff (rst)
        (commit && st_valid) |=> pend_vld[0]);
endmodule

// File: rtl/sbox_table_ram.sv
module sbox_table_ram
    import sbox_pkg::*;
#(
    parameter int DEPTH = WBUF_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  st_entry_t          pend [DEPTH],
    input  logic [DEPTH-1:0]   pend_vld,
    input  logic               rd_en,
    input  logic [WADDR_W-1:0] rd_waddr,
    output logic               rd_valid,
    output logic [ENTRY_W-1:0] rd_data
);
    logic [ENTRY_W-1:0] mem [NWORDS];
    logic [ENTRY_W-1:0] view;

    // Read sees the committing entries in the same cycle; later slots win.
    always_comb begin
        view = mem[rd_waddr];
        for (int i = 0; i < DEPTH; i++)
            if (commit && pend_vld[i] && pend[i].waddr == rd_waddr)
                view = pend[i].data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NWORDS; w++) mem[w] <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (commit)
                for (int i = 0; i < DEPTH; i++)
                    if (pend_vld[i]) mem[pend[i].waddr] <= pend[i].data;
            rd_valid <= rd_en;
            if (rd_en) rd_data <= view;
        end
    end

    a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    a_r2_data_held: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/sbox_lookup_unit.sv
module sbox_lookup_unit
    import sbox_pkg::*;
#(
    parameter int DEPTH = WBUF_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [ENTRY_W-1:0] lk_src,
    input  logic [BSEL_W-1:0]  lk_bsel,
    input  logic [TSEL_W-1:0]  lk_table,
    input  logic               st_valid,
    input  logic [WADDR_W-1:0] st_addr,
    input  logic [ENTRY_W-1:0] st_data,
    input  logic               sync_req,
    input  logic               alias_flag,
    output logic               res_valid,
    output logic [ENTRY_W-1:0] res_data,
    output logic               st_full
);
    logic               commit;
    logic [WADDR_W-1:0] lk_waddr;
    st_entry_t          pend [DEPTH];
    logic [DEPTH-1:0]   pend_vld;

    always_comb commit = sync_req | alias_flag;

    sbox_index_gen u_idx (
        .src   (lk_src),
        .bsel  (lk_bsel),
        .tsel  (lk_table),
        .waddr (lk_waddr)
    );

    sbox_write_buf #(.DEPTH(DEPTH)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .st_valid (st_valid),
        .st_waddr (st_addr),
        .st_data  (st_data),
        .commit   (commit),
        .pend     (pend),
        .pend_vld (pend_vld),
        .full     (st_full)
    );

    sbox_table_ram #(.DEPTH(DEPTH)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .pend     (pend),
        .pend_vld (pend_vld),
        .rd_en    (lk_valid),
        .rd_waddr (lk_waddr),
        .rd_valid (res_valid),
        .rd_data  (res_data)
    );

    a_r7_alias_commits: assert property (@(posedge clk) disable iff (rst)
        alias_flag |=> !st_full);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!res_valid && !st_full));
endmodule

// File: tb/sim_sbox_lookup_unit.sv
`timescale 1ns/1ps
module sim_sbox_lookup_unit;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        lk_valid = 0, st_valid = 0, sync_req = 0, alias_flag = 0;
    logic [31:0] lk_src = 0, st_data = 0;
    logic [1:0]  lk_bsel = 0, lk_table = 0;
    logic [9:0]  st_addr = 0;
    logic        res_valid, st_full;
    logic [31:0] res_data;

    sbox_lookup_unit u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_src(lk_src),
        .lk_bsel(lk_bsel), .lk_table(lk_table), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data), .sync_req(sync_req),
        .alias_flag(alias_flag), .res_valid(res_valid), .res_data(res_data),
        .st_full(st_full)
    );

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit    checking = 0;
    bit    done = 0;

    // Behavioural reference: flat array plus an ordered queue of pending stores.
    logic [31:0] mdl_mem [1024];
    int unsigned q_addr [$];
    logic [31:0] q_data [$];
    logic        exp_valid = 0, exp_full = 0;
    logic [31:0] exp_data = 0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (mdl_mem[i]) mdl_mem[i] = 32'h0;
            q_addr.delete(); q_data.delete();
            exp_valid = 0;
        end else begin
            if (sync_req || alias_flag) begin
                foreach (q_addr[i]) mdl_mem[q_addr[i]] = q_data[i];
                q_addr.delete(); q_data.delete();
            end
            exp_valid = lk_valid;
            if (lk_valid) exp_data = mdl_mem[{lk_table, lk_src[int'(lk_bsel)*8 +: 8]}];
            if (st_valid && q_addr.size() < 4) begin
                q_addr.push_back(int'(st_addr));
                q_data.push_back(st_data);
            end
        end
        exp_full = (q_addr.size() == 4);
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !rst) begin
            chk("res_valid", {31'b0, res_valid}, {31'b0, exp_valid});
            chk("st_full", {31'b0, st_full}, {31'b0, exp_full});
            if (exp_valid) chk("res_data", res_data, exp_data);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        lk_valid = 0; st_valid = 0; sync_req = 0; alias_flag = 0;
    endtask

    task automatic lookup(logic [1:0] tbl, logic [7:0] idx, logic [1:0] sel);
        lk_valid = 1; lk_table = tbl; lk_bsel = sel;
        lk_src = $urandom();
        lk_src[int'(sel)*8 +: 8] = idx;
    endtask

    task automatic store(logic [9:0] a, logic [31:0] d);
        st_valid = 1; st_addr = a; st_data = d;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        checking = 1;
        // R1: reset state, zero contents
        cur_req = "R1";
        for (int k = 0; k < 4; k++) begin lookup(2'(k), 8'(k * 37), 2'(k)); tick(); end
        idle(); tick();
        // R5: store stays invisible
        cur_req = "R5";
        store(10'h15A, 32'hA1A2A3A4); tick(); idle();
        lookup(2'd1, 8'h5A, 2'd2); tick(); idle(); tick();
        // R6: sync and lookup in one cycle
        cur_req = "R6";
        sync_req = 1; lookup(2'd1, 8'h5A, 2'd1); tick(); idle(); tick();
        // R8: two stores to one word, the later wins
        cur_req = "R8";
        store(10'h233, 32'hBBBB0001); tick();
        store(10'h233, 32'hCCCC0002); tick(); idle();
        sync_req = 1; tick(); idle();
        lookup(2'd2, 8'h33, 2'd0); tick(); idle(); tick();
        // R9: store in the commit cycle stays pending
        cur_req = "R9";
        store(10'h010, 32'hDDDD0003); sync_req = 1; tick(); idle();
        lookup(2'd0, 8'h10, 2'd3); tick(); idle();
        sync_req = 1; tick(); idle();
        lookup(2'd0, 8'h10, 2'd3); tick(); idle(); tick();
        // R7: alias flag commits
        cur_req = "R7";
        store(10'h3FF, 32'hEEEE0004); tick(); idle();
        alias_flag = 1; lookup(2'd3, 8'hFF, 2'd1); tick(); idle(); tick();
        // R10: fill the buffer, fifth store dropped
        cur_req = "R10";
        for (int k = 0; k < 5; k++) begin store(10'(10'h080 + k), 32'(32'hF000_0000 + k)); tick(); end
        idle(); tick();
        sync_req = 1; tick(); idle();
        for (int k = 0; k < 5; k++) begin lookup(2'd0, 8'(8'h80 + k), 2'(k)); tick(); end
        idle(); tick();
        // R3 / R4: each table under each byte select
        cur_req = "R4";
        for (int t = 0; t < 4; t++) begin store(10'({2'(t), 8'h6C}), 32'(32'h1100 * (t + 1))); tick(); end
        idle(); sync_req = 1; tick(); idle();
        cur_req = "R3";
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 4; s++) begin lookup(2'(t), 8'h6C, 2'(s)); tick(); end
        idle(); tick();
        // R2: mixed random traffic over a narrow address range
        cur_req = "R2";
        for (int c = 0; c < 4000; c++) begin
            idle();
            if ($urandom_range(0, 1) == 1) lookup(2'($urandom()), 8'($urandom_range(0, 7)), 2'($urandom()));
            if ($urandom_range(0, 2) != 0) store({2'($urandom()), 8'($urandom_range(0, 7))}, $urandom());
            sync_req   = ($urandom_range(0, 9) == 0);
            alias_flag = ($urandom_range(0, 14) == 0);
            tick();
        end
        idle(); tick(); tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule